// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block is the host-facing register file of a legacy PC-style parallel printer port. A host reaches it through a single-cycle synchronous bus over a window of eight byte offsets. Only the low three address bits select a register, so the window repeats across any wider address. Behind the window sit five registers. An output data latch drives the data pins. A status byte is assembled from the synchronized printer lines. A control byte drives the strobe, auto-linefeed, init and select outputs. Two scratch-style byte registers serve as the EPP address and EPP data registers.

The data pins are bidirectional. While the control byte's bidirectional-enable bit is clear, the latch drives the pins and a read of the data offset returns the latch. While that bit is set, the pins are released and a read of the data offset samples the live pins.

A small state machine follows the acknowledge line. It has two states, `IRQ_IDLE` and `IRQ_PEND`. The transition `ACK_SEEN` moves it from idle to pending when a falling edge of the synchronized acknowledge line arrives while interrupts on acknowledge are enabled. The transition `STATUS_READ` moves it back to idle when the host reads the status offset. If `ACK_SEEN` and `STATUS_READ` happen in the same cycle, `ACK_SEEN` wins and the machine stays pending. The pending state is visible as status bit 2 and drives the interrupt request output.

Top module: `lpt_host_regs`

## Requirements
- R1: Only address bits [2:0] select a register. An access at address A behaves exactly like an access at A modulo 8. The offsets are 0 data, 1 status, 2 control, 3 EPP address and 4 EPP data.
- R2: A write to offset 0 loads the data latch, and `pd_out` equals the latch. `pd_oe` is 1 while control bit 5 (bidirectional enable) is 0, and `pd_oe` is 0 while control bit 5 is 1.
- R3: A read of offset 0 returns the data latch when control bit 5 is 0. It returns the value on `pd_in` when control bit 5 is 1.
- R4: A write to offset 2 stores the written byte OR 0xC0, so bits 7:6 always read back as one. Reading offset 2 returns the stored byte. The outputs follow the stored byte as follows: `strobe_o` = bit 0, `autofd_o` = bit 1, `init_o` = bit 2, `select_o` = bit 3.
- R5: A read of offset 1 returns the following bits, each taken from its input after a 2-stage synchronizer:
  - bit 7: `busy_i`
  - bit 6: `ack_i`
  - bit 5: `paper_out_i`
  - bit 4: `select_in_i`
  - bit 3: `error_i`
  - bit 2: interrupt pending
  - bit 1: always 0
  - bit 0: `epp_timeout_i`
- R6: A falling edge of the synchronized `ack_i` while control bit 4 is 1 sets status bit 2 and raises `irq_o`. With control bit 4 at 0, such an edge changes neither status bit 2 nor `irq_o`.
- R7: A read of offset 1 returns status bit 2 as it was before the read and then clears it, which drops `irq_o`. An acknowledge edge in the same cycle as the read keeps the bit set.
- R8: Offsets 3 and 4 are independent byte registers. Each one reads back the last value written to it.
- R9: Writes to offsets 5, 6 and 7 change no register. Reads of those offsets return 0x00.
- R10: `bus_rdata` is registered. It updates on the clock edge that samples `bus_rd` and holds its value while `bus_rd` is low.
- R11: After reset the data latch and both EPP registers are 0x00, the control byte is 0xC0, nothing is pending, `irq_o` is 0 and `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address; only bits [2:0] decoded |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pd_in | input | 8 | Sampled data pins |
| pd_out | output | 8 | Data pin drive value |
| pd_oe | output | 1 | Data pin output enable |
| busy_i | input | 1 | Printer busy line |
| ack_i | input | 1 | Printer acknowledge line |
| paper_out_i | input | 1 | Paper-out line |
| select_in_i | input | 1 | Printer selected line |
| error_i | input | 1 | Printer error line |
| epp_timeout_i | input | 1 | EPP timeout indication |
| strobe_o | output | 1 | Strobe output (control bit 0) |
| autofd_o | output | 1 | Auto-linefeed output (control bit 1) |
| init_o | output | 1 | Init/reset output (control bit 2) |
| select_o | output | 1 | Select-printer output (control bit 3) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with `ADDR_W` = 4 and `SYNC_STAGES` = 2. With a 4-bit address, every offset can be reached both directly and through its alias with bit 3 set, which exercises the decode rule of R1. The narrow data path lets the bench sweep all 256 data-latch values in both directions of the pins. It also sweeps all 64 low control patterns and all 64 combinations of the six status inputs, computing each expected byte arithmetically.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int BYTE_W = 8;
    localparam int OFF_W  = 3;

    localparam logic [OFF_W-1:0] OFF_DATA  = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STAT  = 3'd1;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 3'd2;
    localparam logic [OFF_W-1:0] OFF_EADDR = 3'd3;
    localparam logic [OFF_W-1:0] OFF_EDATA = 3'd4;

    // control bit positions
    localparam int CB_STROBE = 0;
    localparam int CB_AUTOFD = 1;
    localparam int CB_INIT   = 2;
    localparam int CB_SELECT = 3;
    localparam int CB_IRQEN  = 4;
    localparam int CB_BIDIR  = 5;

    localparam logic [BYTE_W-1:0] CTRL_RSVD = 8'hC0;

    // synchronized line vector index
    localparam int LN_TMO   = 0;
    localparam int LN_ERR   = 1;
    localparam int LN_SEL   = 2;
    localparam int LN_PAPER = 3;
    localparam int LN_ACK   = 4;
    localparam int LN_BUSY  = 5;
    localparam int LN_COUNT = 6;

    typedef enum logic [0:0] {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_t;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lpt_irq_fsm.sv
module lpt_irq_fsm
    import lpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_s_i,
    input  logic irq_en_i,
    input  logic status_rd_i,
    output logic pending_o
);
    irq_state_t state_q, state_d;
    logic       ack_prev_q;
    logic       ack_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_prev_q <= 1'b0;
        else        ack_prev_q <= ack_s_i;
    end

    assign ack_fall = ack_prev_q & ~ack_s_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // next state: ACK_SEEN has priority over STATUS_READ
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (ack_fall && irq_en_i) state_d = IRQ_PEND;
            IRQ_PEND: if (status_rd_i && !(ack_fall && irq_en_i)) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IRQ_PEND: pending_o = 1'b1;
            default:  pending_o = 1'b0;
        endcase
    end

    a_r6_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> $past(irq_en_i));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && status_rd_i && !ack_fall) |=> !pending_o);

    a_r7_edge_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fall && irq_en_i) |=> pending_o);
endmodule

// File: rtl/lpt_host_regs.sv
module lpt_host_regs
    import lpt_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        pd_in,
    output logic [7:0]        pd_out,
    output logic              pd_oe,
    input  logic              busy_i,
    input  logic              ack_i,
    input  logic              paper_out_i,
    input  logic              select_in_i,
    input  logic              error_i,
    input  logic              epp_timeout_i,
    output logic              strobe_o,
    output logic              autofd_o,
    output logic              init_o,
    output logic              select_o,
    output logic              irq_o
);
    logic [OFF_W-1:0]    off;
    logic [BYTE_W-1:0]   data_q, ctrl_q, eaddr_q, edata_q, rdata_q;
    logic [BYTE_W-1:0]   ctrl_new, rd_mux, status_byte;
    logic [LN_COUNT-1:0] lines_raw, lines_s;
    logic                pending;
    logic                status_rd;
    logic                ctrl_we;

    assign off = bus_addr[OFF_W-1:0];

    assign lines_raw[LN_TMO]   = epp_timeout_i;
    assign lines_raw[LN_ERR]   = error_i;
    assign lines_raw[LN_SEL]   = select_in_i;
    assign lines_raw[LN_PAPER] = paper_out_i;
    assign lines_raw[LN_ACK]   = ack_i;
    assign lines_raw[LN_BUSY]  = busy_i;

    lpt_sync #(.WIDTH(LN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (lines_raw),
        .q_o   (lines_s)
    );

    assign status_rd = bus_rd && (off == OFF_STAT);

    lpt_irq_fsm u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_s_i     (lines_s[LN_ACK]),
        .irq_en_i    (ctrl_q[CB_IRQEN]),
        .status_rd_i (status_rd),
        .pending_o   (pending)
    );

    assign status_byte = {lines_s[LN_BUSY], lines_s[LN_ACK], lines_s[LN_PAPER],
                          lines_s[LN_SEL], lines_s[LN_ERR], pending, 1'b0,
                          lines_s[LN_TMO]};

    // control is stored only when the forced value differs
    assign ctrl_new = bus_wdata | CTRL_RSVD;
    assign ctrl_we  = bus_wr && (off == OFF_CTRL) && (ctrl_new != ctrl_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            ctrl_q  <= CTRL_RSVD;
            eaddr_q <= '0;
            edata_q <= '0;
        end else begin
            if (bus_wr && off == OFF_DATA)  data_q  <= bus_wdata;
            if (ctrl_we)                    ctrl_q  <= ctrl_new;
            if (bus_wr && off == OFF_EADDR) eaddr_q <= bus_wdata;
            if (bus_wr && off == OFF_EDATA) edata_q <= bus_wdata;
        end
    end

    always_comb begin
        unique case (off)
            OFF_DATA:  rd_mux = ctrl_q[CB_BIDIR] ? pd_in : data_q;
            OFF_STAT:  rd_mux = status_byte;
            OFF_CTRL:  rd_mux = ctrl_q;
            OFF_EADDR: rd_mux = eaddr_q;
            OFF_EDATA: rd_mux = edata_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign pd_out    = data_q;
    assign pd_oe     = ~ctrl_q[CB_BIDIR];
    assign strobe_o  = ctrl_q[CB_STROBE];
    assign autofd_o  = ctrl_q[CB_AUTOFD];
    assign init_o    = ctrl_q[CB_INIT];
    assign select_o  = ctrl_q[CB_SELECT];
    assign irq_o     = pending;

    a_r2_data_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off == OFF_DATA) |=> (pd_out == $past(bus_wdata)));

    a_r4_ctrl_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off == OFF_CTRL) |=> (ctrl_q == ($past(bus_wdata) | 8'hC0)));

    a_r8_epp_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off == OFF_EADDR) |=> (eaddr_q == $past(bus_wdata)));

    a_r9_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off > OFF_EDATA) |=> ($stable(data_q) && $stable(ctrl_q)
                                          && $stable(eaddr_q) && $stable(edata_q)));

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_lpt_host_regs.sv
module tb_lpt_host_regs;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [7:0]    pd_in = '0;
    logic [7:0]    pd_out;
    logic          pd_oe;
    logic          busy_i = 0, ack_i = 1, paper_out_i = 0, select_in_i = 0, error_i = 0, epp_timeout_i = 0;
    logic          strobe_o, autofd_o, init_o, select_o, irq_o;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpt_host_regs #(.ADDR_W(AW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_in(pd_in), .pd_out(pd_out),
        .pd_oe(pd_oe), .busy_i(busy_i), .ack_i(ack_i), .paper_out_i(paper_out_i),
        .select_in_i(select_in_i), .error_i(error_i), .epp_timeout_i(epp_timeout_i),
        .strobe_o(strobe_o), .autofd_o(autofd_o), .init_o(init_o), .select_o(select_o),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] hold;
        idle(2);
        // R11 reset state
        check("R11 rdata", bus_rdata, 8'h00);
        check("R11 irq", {7'd0, irq_o}, 8'h00);
        rst_n = 1'b1;
        idle(4);
        rd(2, v); check("R11 ctrl", v, 8'hC0);
        rd(0, v); check("R11 data", v, 8'h00);
        rd(3, v); check("R11 eaddr", v, 8'h00);
        rd(4, v); check("R11 edata", v, 8'h00);

        // R2 / R3 sweep of data values, both pin directions
        for (int i = 0; i < 256; i++) begin
            pd_in = ~i[7:0];
            wr(0, i[7:0]);
            check("R2 pd_out", pd_out, i[7:0]);
            check("R2 pd_oe", {7'd0, pd_oe}, 8'h01);
            rd(0, v); check("R3 latch read", v, i[7:0]);
        end
        wr(2, 8'h20);
        check("R2 pd_oe bidir", {7'd0, pd_oe}, 8'h00);
        for (int i = 0; i < 256; i++) begin
            pd_in = i[7:0] ^ 8'h5A;
            rd(0, v); check("R3 pin read", v, i[7:0] ^ 8'h5A);
        end
        wr(2, 8'h00);

        // R4 sweep of low control patterns
        for (int i = 0; i < 64; i++) begin
            wr(2, i[7:0]);
            rd(2, v); check("R4 ctrl readback", v, i[7:0] | 8'hC0);
            check("R4 pins", {4'd0, select_o, init_o, autofd_o, strobe_o}, {4'd0, i[3:0]});
        end
        wr(2, 8'h00);

        // R5 sweep of status inputs
        for (int i = 0; i < 64; i++) begin
            {busy_i, ack_i, paper_out_i, select_in_i, error_i, epp_timeout_i} = i[5:0];
            idle(4);
            rd(1, v);
            check("R5 status", v, {i[5:1], 2'b00, i[0]});
        end
        {busy_i, paper_out_i, select_in_i, error_i, epp_timeout_i} = '0;
        ack_i = 1'b1;
        idle(4);

        // R6 edge with enable clear: nothing
        ack_i = 1'b0; idle(6);
        check("R6 disabled irq", {7'd0, irq_o}, 8'h00);
        rd(1, v); check("R6 disabled bit2", v & 8'h04, 8'h00);
        ack_i = 1'b1; idle(4);

        // R6 edge with enable set
        wr(2, 8'h10);
        ack_i = 1'b0; idle(6);
        check("R6 irq raised", {7'd0, irq_o}, 8'h01);
        // R7 read returns bit and clears it
        rd(1, v); check("R7 bit2 seen", v & 8'h04, 8'h04);
        check("R7 irq cleared", {7'd0, irq_o}, 8'h00);
        rd(1, v); check("R7 bit2 gone", v & 8'h04, 8'h00);
        ack_i = 1'b1; idle(4);
        wr(2, 8'h00);

        // R8 EPP registers, independent
        for (int i = 0; i < 256; i += 17) begin
            wr(3, i[7:0]);
            wr(4, ~i[7:0]);
            rd(3, v); check("R8 eaddr", v, i[7:0]);
            rd(4, v); check("R8 edata", v, ~i[7:0]);
        end

        // R9 high offsets ignore writes, read zero
        wr(0, 8'h3C); wr(3, 8'h11); wr(4, 8'h22); wr(2, 8'h05);
        for (int a = 5; a < 8; a++) begin
            wr(a[AW-1:0], 8'hFF);
            rd(a[AW-1:0], v); check("R9 read zero", v, 8'h00);
        end
        rd(0, v); check("R9 data kept", v, 8'h3C);
        rd(2, v); check("R9 ctrl kept", v, 8'hC5);
        rd(3, v); check("R9 eaddr kept", v, 8'h11);
        rd(4, v); check("R9 edata kept", v, 8'h22);

        // R1 aliasing via bit 3
        wr(4'hB, 8'h77); rd(3, v); check("R1 alias write", v, 8'h77);
        wr(4'h4, 8'h66); rd(4'hC, v); check("R1 alias read", v, 8'h66);
        wr(4'hA, 8'h02); check("R1 alias ctrl", {7'd0, autofd_o}, 8'h01);

        // R10 rdata holds without read
        rd(3, hold);
        wr(3, 8'h99);
        idle(3);
        check("R10 hold", bus_rdata, hold);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule